// File: doc/BRIEF.md
# Clock display-mode and adjust controller

This controller decides what a six-digit clock display shows and which field is open for editing. Its inputs are four single-cycle key pulses that are already debounced (switch, adjust, up, down) and a shared one-second tick. Its outputs are a display-source select, a field-select code, a one-hot blink-group select, a blank mask that carries the half-second blink, and single-cycle step requests for the counter storage. The counter storage and the seven-segment driver sit outside this block.

Outside edit mode, the switch key rotates through three views: time, date and alarm time. Pressing adjust while the time view is shown opens edit mode at the minutes field. In edit mode, switch moves to the next field in this order: minutes, hours, day, month, year, and then minutes again. Up and down send step requests for the open field. A second adjust press closes edit mode. Edit mode also closes by itself after twenty whole seconds with no key press. In both cases the block returns to the time view.

The states are ST_SHOW_TIME, ST_SHOW_DATE, ST_SHOW_ALARM, ST_EDIT_MIN, ST_EDIT_HOUR, ST_EDIT_DAY, ST_EDIT_MONTH and ST_EDIT_YEAR. The transitions are as follows:
- In the show states, switch steps TIME→DATE→ALARM→TIME.
- In TIME, adjust leads to EDIT_MIN.
- In the edit states, switch steps MIN→HOUR→DAY→MONTH→YEAR→MIN.
- Any edit state leads to TIME on adjust or on the idle timeout.

Top module: `disp_edit_ctrl`

## Requirements
- R1: After reset the block shows the time view (view_src 0), edit_active is 0, blink_sel and blank_mask are 0, and no step pulse is asserted.
- R2: Outside edit mode, each switch press advances view_src one clock later, from 0 (time) to 1 (date) to 2 (alarm) and back to 0.
- R3: Adjust in the time view enters edit mode at the minutes field (field_sel 0) with view_src 0. Adjust in the date or alarm view is ignored.
- R4: In edit mode, each switch press advances field_sel through 0 minutes, 1 hours, 2 day, 3 month, 4 year and back to 0. While editing, view_src is 0 for fields 0 and 1 and 1 for fields 2 to 4.
- R5: Adjust in edit mode leaves edit mode and returns to the time view. Edits already sent are not undone.
- R6: Edit mode is left for the time view on the IDLE_SECONDS-th (default 20) sec_tick that arrives with no key pressed since entry or since the last key press. Any key press restarts this count.
- R7: blink_sel is one-hot in edit mode and zero outside it. Bit 2 is the left pair, bit 1 the middle pair and bit 0 the right pair. Minutes use the middle pair, hours the left, day the right, month the middle and year the left.
- R8: blank_mask is zero during the lit half of the blink and equals blink_sel during the dark half. The blink starts lit on entry to edit mode and toggles every HALF_PERIOD cycles (0.5 s by default).
- R9: In edit mode, a lone up or down press produces step_up or step_down for exactly one cycle, one clock later, with step_field equal to the field that was selected when the key was pressed. There is no step outside edit mode, when up and down come together, or when either comes with switch or adjust.
- R10: When adjust and switch arrive in the same cycle in the time view or in edit mode, adjust takes effect and switch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_switch | input | 1 | Switch key pulse |
| key_adjust | input | 1 | Adjust key pulse |
| key_up | input | 1 | Up key pulse |
| key_down | input | 1 | Down key pulse |
| sec_tick | input | 1 | One-cycle pulse once per second |
| view_src | output | 2 | Display source: 0 time, 1 date, 2 alarm |
| field_sel | output | 3 | Edited field code, 0 outside edit mode |
| blink_sel | output | 3 | One-hot digit pair being edited |
| blank_mask | output | 3 | Digit pairs to blank during this half-second |
| step_up | output | 1 | Increment request for step_field |
| step_down | output | 1 | Decrement request for step_field |
| step_field | output | 3 | Field that a step request applies to |
| edit_active | output | 1 | High while in edit mode |

## Verification
The assertions assume that every key input is a clean pulse sampled on the rising edge. They allow several keys in the same cycle but require that none is held across reset. They also assume sec_tick is a single-cycle pulse. The bench drives each key for exactly one cycle at the falling edge, sometimes in deliberate pairs to exercise priority and cancellation. It generates sec_tick as a one-cycle pulse every ten clocks, so every input stays within what the properties expect.

// File: rtl/disp_edit_pkg.sv
package disp_edit_pkg;

    typedef enum logic [2:0] {
        ST_SHOW_TIME,
        ST_SHOW_DATE,
        ST_SHOW_ALARM,
        ST_EDIT_MIN,
        ST_EDIT_HOUR,
        ST_EDIT_DAY,
        ST_EDIT_MONTH,
        ST_EDIT_YEAR
    } ctl_state_e;

    typedef enum logic [2:0] {
        FLD_MIN   = 3'd0,
        FLD_HOUR  = 3'd1,
        FLD_DAY   = 3'd2,
        FLD_MONTH = 3'd3,
        FLD_YEAR  = 3'd4
    } field_e;

    typedef enum logic [1:0] {
        SRC_TIME  = 2'd0,
        SRC_DATE  = 2'd1,
        SRC_ALARM = 2'd2
    } src_e;

    localparam int GROUPS    = 3;
    localparam int GRP_RIGHT = 0;
    localparam int GRP_MID   = 1;
    localparam int GRP_LEFT  = 2;

    typedef struct packed {
        logic sw;
        logic adj;
        logic up;
        logic dn;
    } keys_t;

endpackage

// File: rtl/dec_idle_timer.sv
module dec_idle_timer
    import disp_edit_pkg::*;
#(
    parameter int IDLE_SECONDS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic any_key,
    input  logic sec_tick,
    output logic expire
);
    localparam int IW = $clog2(IDLE_SECONDS + 1);
    localparam logic [IW-1:0] LAST = IW'(IDLE_SECONDS - 1);

    logic [IW-1:0] secs_q;

    // fires on the tick that completes the idle window
    assign expire = active && !any_key && sec_tick && (secs_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            secs_q <= '0;
        end else if (!active || any_key || expire) begin
            secs_q <= '0;
        end else if (sec_tick) begin
            secs_q <= secs_q + 1'b1;
        end
    end
endmodule

// File: rtl/dec_blink_phase.sv
module dec_blink_phase
    import disp_edit_pkg::*;
#(
    parameter int HALF_PERIOD = 62_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic dark
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] WRAP = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          dark_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q  <= '0;
            dark_q <= 1'b0;
        end else if (cnt_q == WRAP) begin
            cnt_q  <= '0;
            dark_q <= !dark_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dark = dark_q;
endmodule

// File: rtl/dec_mode_fsm.sv
module dec_mode_fsm
    import disp_edit_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  keys_t               keys,
    input  logic                expire,
    output logic                edit_active,
    output field_e              field,
    output src_e                src,
    output logic [GROUPS-1:0]   group_sel
);
    ctl_state_e cur_q, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_SHOW_TIME;
        else     cur_q <= nxt;
    end

    // transitions
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_SHOW_TIME: begin
                if (keys.adj)     nxt = ST_EDIT_MIN;
                else if (keys.sw) nxt = ST_SHOW_DATE;
            end
            ST_SHOW_DATE: begin
                if (keys.sw) nxt = ST_SHOW_ALARM;
            end
            ST_SHOW_ALARM: begin
                if (keys.sw) nxt = ST_SHOW_TIME;
            end
            ST_EDIT_MIN: begin
                if (keys.adj)     nxt = ST_SHOW_TIME;
                else if (keys.sw) nxt = ST_EDIT_HOUR;
                else if (expire)  nxt = ST_SHOW_TIME;
            end
            ST_EDIT_HOUR: begin
                if (keys.adj)     nxt = ST_SHOW_TIME;
                else if (keys.sw) nxt = ST_EDIT_DAY;
                else if (expire)  nxt = ST_SHOW_TIME;
            end
            ST_EDIT_DAY: begin
                if (keys.adj)     nxt = ST_SHOW_TIME;
                else if (keys.sw) nxt = ST_EDIT_MONTH;
                else if (expire)  nxt = ST_SHOW_TIME;
            end
            ST_EDIT_MONTH: begin
                if (keys.adj)     nxt = ST_SHOW_TIME;
                else if (keys.sw) nxt = ST_EDIT_YEAR;
                else if (expire)  nxt = ST_SHOW_TIME;
            end
            ST_EDIT_YEAR: begin
                if (keys.adj)     nxt = ST_SHOW_TIME;
                else if (keys.sw) nxt = ST_EDIT_MIN;
                else if (expire)  nxt = ST_SHOW_TIME;
            end
        endcase
    end

    // outputs
    always_comb begin
        edit_active = 1'b0;
        field       = FLD_MIN;
        src         = SRC_TIME;
        group_sel   = '0;
        unique case (cur_q)
            ST_SHOW_TIME:  src = SRC_TIME;
            ST_SHOW_DATE:  src = SRC_DATE;
            ST_SHOW_ALARM: src = SRC_ALARM;
            ST_EDIT_MIN: begin
                edit_active        = 1'b1;
                field              = FLD_MIN;
                src                = SRC_TIME;
                group_sel[GRP_MID] = 1'b1;
            end
            ST_EDIT_HOUR: begin
                edit_active         = 1'b1;
                field               = FLD_HOUR;
                src                 = SRC_TIME;
                group_sel[GRP_LEFT] = 1'b1;
            end
            ST_EDIT_DAY: begin
                edit_active          = 1'b1;
                field                = FLD_DAY;
                src                  = SRC_DATE;
                group_sel[GRP_RIGHT] = 1'b1;
            end
            ST_EDIT_MONTH: begin
                edit_active        = 1'b1;
                field              = FLD_MONTH;
                src                = SRC_DATE;
                group_sel[GRP_MID] = 1'b1;
            end
            ST_EDIT_YEAR: begin
                edit_active         = 1'b1;
                field               = FLD_YEAR;
                src                 = SRC_DATE;
                group_sel[GRP_LEFT] = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/disp_edit_ctrl.sv
module disp_edit_ctrl
    import disp_edit_pkg::*;
#(
    parameter int HALF_PERIOD  = 62_500_000,
    parameter int IDLE_SECONDS = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_switch,
    input  logic       key_adjust,
    input  logic       key_up,
    input  logic       key_down,
    input  logic       sec_tick,
    output logic [1:0] view_src,
    output logic [2:0] field_sel,
    output logic [2:0] blink_sel,
    output logic [2:0] blank_mask,
    output logic       step_up,
    output logic       step_down,
    output logic [2:0] step_field,
    output logic       edit_active
);
    keys_t              keys;
    logic               any_key;
    logic               expire;
    logic               dark;
    logic               edit_i;
    field_e             field_i;
    src_e               src_i;
    logic [GROUPS-1:0]  grp_i;
    logic               lone_step;
    logic               up_q, dn_q;
    logic [2:0]         fld_q;

    assign keys    = {key_switch, key_adjust, key_up, key_down};
    assign any_key = |keys;

    dec_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .keys        (keys),
        .expire      (expire),
        .edit_active (edit_i),
        .field       (field_i),
        .src         (src_i),
        .group_sel   (grp_i)
    );

    dec_idle_timer #(.IDLE_SECONDS(IDLE_SECONDS)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .active   (edit_i),
        .any_key  (any_key),
        .sec_tick (sec_tick),
        .expire   (expire)
    );

    dec_blink_phase #(.HALF_PERIOD(HALF_PERIOD)) u_blink (
        .clk    (clk),
        .rst    (rst),
        .active (edit_i),
        .dark   (dark)
    );

    // a step is only issued for a lone up or down press
    assign lone_step = edit_i && !keys.sw && !keys.adj && (keys.up ^ keys.dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q  <= 1'b0;
            dn_q  <= 1'b0;
            fld_q <= '0;
        end else begin
            up_q  <= lone_step && keys.up;
            dn_q  <= lone_step && keys.dn;
            fld_q <= field_i;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_blank
        assign blank_mask[g] = grp_i[g] & dark;
    end

    assign view_src    = src_i;
    assign field_sel   = field_i;
    assign blink_sel   = grp_i;
    assign edit_active = edit_i;
    assign step_up     = up_q;
    assign step_down   = dn_q;
    assign step_field  = fld_q;
endmodule

// File: rtl/disp_edit_ctrl_chk.sv
module disp_edit_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       key_switch,
    input logic       key_adjust,
    input logic       key_up,
    input logic       key_down,
    input logic [1:0] view_src,
    input logic [2:0] field_sel,
    input logic [2:0] blink_sel,
    input logic [2:0] blank_mask,
    input logic       step_up,
    input logic       step_down,
    input logic [2:0] step_field,
    input logic       edit_active
);
    p_view_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!edit_active && key_switch && !key_adjust && view_src == 2'd2) |=> (view_src == 2'd0));

    p_enter_min_r3: assert property (@(posedge clk) disable iff (rst)
        (!edit_active && view_src == 2'd0 && key_adjust) |=> (edit_active && field_sel == 3'd0));

    p_field_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (edit_active && key_switch && !key_adjust && field_sel == 3'd4) |=> (field_sel == 3'd0));

    p_confirm_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (edit_active && key_adjust) |=> (!edit_active && view_src == 2'd0));

    p_blink_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        edit_active |-> ($countones(blink_sel) == 1));

    p_blink_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !edit_active |-> (blink_sel == 3'b000));

    p_blank_subset_r8: assert property (@(posedge clk) disable iff (rst)
        ((blank_mask & ~blink_sel) == 3'b000));

    p_step_source_r9: assert property (@(posedge clk) disable iff (rst)
        step_up |-> ($past(edit_active) && $past(key_up) && !$past(key_down)
                     && step_field == $past(field_sel)));

    p_step_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(step_up && step_down));

    p_step_single_r9: assert property (@(posedge clk) disable iff (rst)
        step_down |=> !step_down || $past(key_down));

    p_adjust_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (!edit_active && view_src == 2'd0 && key_adjust && key_switch) |=> (view_src == 2'd0));
endmodule

bind disp_edit_ctrl disp_edit_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .key_switch  (key_switch),
    .key_adjust  (key_adjust),
    .key_up      (key_up),
    .key_down    (key_down),
    .view_src    (view_src),
    .field_sel   (field_sel),
    .blink_sel   (blink_sel),
    .blank_mask  (blank_mask),
    .step_up     (step_up),
    .step_down   (step_down),
    .step_field  (step_field),
    .edit_active (edit_active)
);

// File: tb/disp_edit_ctrl_bench.sv
module disp_edit_ctrl_bench;
    localparam int HALF = 6;
    localparam int IDLE = 20;
    localparam int TICK_GAP = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_switch = 0, key_adjust = 0, key_up = 0, key_down = 0;
    logic sec_tick = 0;
    logic [1:0] view_src;
    logic [2:0] field_sel, blink_sel, blank_mask, step_field;
    logic step_up, step_down, edit_active;

    always #4 clk = ~clk;

    disp_edit_ctrl #(.HALF_PERIOD(HALF), .IDLE_SECONDS(IDLE)) u_disp_edit_ctrl (
        .clk(clk), .rst(rst),
        .key_switch(key_switch), .key_adjust(key_adjust),
        .key_up(key_up), .key_down(key_down), .sec_tick(sec_tick),
        .view_src(view_src), .field_sel(field_sel), .blink_sel(blink_sel),
        .blank_mask(blank_mask), .step_up(step_up), .step_down(step_down),
        .step_field(step_field), .edit_active(edit_active)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_view, m_fld, m_idle, m_hc, m_sf;
    bit m_edit, m_dark, m_su, m_sd;

    function automatic int grp_of(input int f);
        case (f)
            0: return 2; 1: return 4; 2: return 1; 3: return 2; default: return 4;
        endcase
    endfunction

    always @(posedge clk) begin
        bit anyk, tout, adj_eff;
        if (rst) begin
            m_view = 0; m_fld = 0; m_idle = 0; m_hc = 0; m_sf = 0;
            m_edit = 0; m_dark = 0; m_su = 0; m_sd = 0;
        end else begin
            anyk = key_switch | key_adjust | key_up | key_down;
            m_su = m_edit && key_up && !key_down && !key_switch && !key_adjust;
            m_sd = m_edit && key_down && !key_up && !key_switch && !key_adjust;
            m_sf = m_edit ? m_fld : 0;
            tout = 0;
            if (!m_edit || anyk) m_idle = 0;
            else if (sec_tick) begin
                if (m_idle == IDLE - 1) begin tout = 1; m_idle = 0; end
                else m_idle++;
            end
            if (!m_edit) begin m_hc = 0; m_dark = 0; end
            else if (m_hc == HALF - 1) begin m_hc = 0; m_dark = !m_dark; end
            else m_hc++;
            adj_eff = key_adjust && (m_edit || m_view == 0);
            if (adj_eff) begin
                if (m_edit) begin m_edit = 0; m_view = 0; end
                else begin m_edit = 1; m_fld = 0; end
            end else if (key_switch) begin
                if (m_edit) m_fld = (m_fld + 1) % 5;
                else m_view = (m_view + 1) % 3;
            end else if (tout) begin
                m_edit = 0; m_view = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int eb;
            eb = m_edit ? grp_of(m_fld) : 0;
            chk("R2", "view_src", view_src, m_edit ? (m_fld < 2 ? 0 : 1) : m_view);
            chk("R6", "edit_active", edit_active, m_edit);
            chk("R4", "field_sel", field_sel, m_edit ? m_fld : 0);
            chk("R7", "blink_sel", blink_sel, eb);
            chk("R8", "blank_mask", blank_mask, m_dark ? eb : 0);
            chk("R9", "step_up", step_up, m_su);
            chk("R9", "step_down", step_down, m_sd);
            chk("R9", "step_field", step_field, m_sf);
        end
    end

    // ---------------- stimulus ----------------
    bit tick_en = 0;
    int tcnt = 0;
    always @(negedge clk) begin
        if (tick_en) begin
            tcnt++;
            sec_tick <= (tcnt % TICK_GAP == 0);
        end else sec_tick <= 1'b0;
    end

    task automatic keys(input bit s, input bit a, input bit u, input bit d);
        @(negedge clk);
        key_switch = s; key_adjust = a; key_up = u; key_down = d;
        @(negedge clk);
        key_switch = 0; key_adjust = 0; key_up = 0; key_down = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "view_src", view_src, 0);
        chk("R1", "edit_active", edit_active, 0);
        chk("R1", "blink_sel", blink_sel, 0);
        chk("R1", "step_up", step_up, 0);

        keys(1,0,0,0); chk("R2", "view date", view_src, 1);
        keys(0,1,0,0); chk("R3", "adjust ignored in date", edit_active, 0);
        keys(1,0,0,0); chk("R2", "view alarm", view_src, 2);
        keys(0,1,0,0); chk("R3", "adjust ignored in alarm", edit_active, 0);
        keys(1,0,0,0); chk("R2", "view wraps to time", view_src, 0);

        keys(0,1,0,0);
        chk("R3", "enter edit", edit_active, 1);
        chk("R3", "field min", field_sel, 0);
        chk("R7", "min middle pair", blink_sel, 2);
        chk("R8", "starts lit", blank_mask, 0);
        keys(0,0,1,0);
        chk("R9", "step_up pulse", step_up, 1);
        chk("R9", "step tag", step_field, 0);
        @(negedge clk); chk("R9", "step_up one cycle", step_up, 0);
        keys(0,0,1,1); chk("R9", "up+down cancels", step_up | step_down, 0);
        keys(1,0,0,1);
        chk("R9", "down+switch no step", step_down, 0);
        chk("R4", "field hour", field_sel, 1);
        chk("R7", "hour left pair", blink_sel, 4);
        keys(0,0,0,1); chk("R9", "step_down tag hour", step_field, 1);
        keys(1,0,0,0); chk("R4", "field day", field_sel, 2); chk("R4", "date source", view_src, 1);
        chk("R7", "day right pair", blink_sel, 1);
        keys(1,0,0,0); chk("R4", "field month", field_sel, 3);
        keys(1,0,0,0); chk("R4", "field year", field_sel, 4); chk("R7", "year left", blink_sel, 4);
        keys(1,0,0,0); chk("R4", "field wraps", field_sel, 0);
        repeat (3 * HALF) @(negedge clk);

        keys(0,1,0,0); chk("R5", "confirm leaves", edit_active, 0); chk("R5", "time view", view_src, 0);
        keys(0,0,1,0); chk("R9", "no step outside edit", step_up, 0);

        keys(0,1,0,0);
        repeat (HALF - 1) @(negedge clk);
        chk("R8", "still lit", blank_mask, 0);
        @(negedge clk);
        chk("R8", "dark half", blank_mask, 2);
        repeat (HALF) @(negedge clk);
        chk("R8", "lit again", blank_mask, 0);
        keys(0,1,0,0);

        tick_en = 1;
        keys(0,1,0,0);
        repeat (150) @(negedge clk);
        chk("R6", "within window", edit_active, 1);
        keys(0,0,1,0);
        repeat (150) @(negedge clk);
        chk("R6", "key restarts count", edit_active, 1);
        repeat (100) @(negedge clk);
        chk("R6", "idle exit", edit_active, 0);
        chk("R6", "idle exit view", view_src, 0);
        tick_en = 0;

        keys(1,1,0,0);
        chk("R10", "adjust wins in time view", edit_active, 1);
        chk("R10", "field min", field_sel, 0);
        keys(1,1,0,0);
        chk("R10", "adjust wins in edit", edit_active, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule